// File: doc/BRIEF.md
# External Bus Area Decoder with Wait Control

This block sits between a CPU's external-access request and the external bus pins. It splits the address space into eight fixed areas and picks one of them from three address bits. It drives one chip-select for the chosen area and reports the bus width that area is set up for. It then counts out the access, ending it with a one-cycle ready pulse. Each area is set up through a small write port: a bus-width bit for every area, a long-wait field for the three areas that support one, and a DRAM-span bit for area 1 that widens its address range.

An access begins when the requester raises `req_valid` while the block is idle. The requester holds its request until `ready`. Every byte cycle on the bus takes one base cycle, plus any programmed long waits, plus any further cycles for which the synchronized external wait line is still high once the long waits are over. A 16-bit request to an 8-bit area runs as two byte cycles, and the high byte goes first. Between two accesses the bus always goes through one cycle with every chip-select low.

Top module: `ext_bus_area_ctrl`

## Requirements
- R1: The area number is address bits [24:22]. From the cycle after acceptance up to and including the ready cycle, exactly the chip-select bit of that area is high and it does not change. Outside an access all chip-selects are low.
- R2: When the DRAM-span bit is set (written with `cfg_area` = 1), area fields 1, 2, 3 and 4 all select chip-select 1. When it is clear, each of those fields selects its own area. Field 5 always selects area 5.
- R3: During an access, `bus_wide` shows the width bit stored for the selected area (1 = 16-bit, 0 = 8-bit; every area resets to 8-bit), and `bus_we` shows the request's write flag. Both are low outside an access.
- R4: Areas 0, 2 and 6 insert v+1 long-wait cycles, where v is the 2-bit field written for that area. An unsplit access to one of them therefore lasts v+2 cycles, counted from the cycle after acceptance through the ready cycle. The field resets to 0.
- R5: On areas 1, 3, 4, 5 and 7, writes to the long-wait field have no effect, and an unsplit access lasts exactly 1 cycle.
- R6: A word request (`req_word` = 1) to an 8-bit area runs as two byte cycles. Each byte cycle has the full wait sequence. `half_hi` is high during the first (high-byte) cycle only, and `ready` comes only at the end of the second. A byte request, or a word request to a 16-bit area, runs as a single byte cycle.
- R7: `ext_wait` passes through two flip-flops. Once the long waits have elapsed, each cycle in which the synchronized value is high extends the access. After `ext_wait` falls, `ready` appears in the second cycle.
- R8: A pulse on `ext_wait` that has left the synchronizer before the long waits end does not change the length of the access.
- R9: `ready` is high for exactly one cycle per access. A request still held in the ready cycle is not taken again at that edge, so at least one cycle with all chip-selects low comes between two accesses.
- R10: After reset, all chip-selects, `ready`, `half_hi`, `bus_wide` and `bus_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until ready |
| req_addr | input | 25 | Access address; bits [24:22] pick the area |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_area | input | 3 | Area being configured |
| cfg_wide | input | 1 | Bus width for that area (1 = 16-bit) |
| cfg_lwait | input | 2 | Long-wait field (waits = value + 1), kept only for areas 0, 2 and 6 |
| cfg_dram | input | 1 | DRAM-span bit, kept only when cfg_area = 1 |
| ext_wait | input | 1 | Asynchronous external wait request |
| cs | output | 8 | One chip-select per area |
| bus_wide | output | 1 | Width of the current bus access |
| bus_we | output | 1 | Write flag of the current access |
| half_hi | output | 1 | First (high-byte) half of a split access |
| ready | output | 1 | One-cycle access completion |

## Verification
The access length is measured for areas with and without a long wait, at the reset setting and at programmed settings. An area that refuses long-wait writes and the areas that accept them are set to the same value, so a wrong area mask shows up as a different cycle count. Word and byte requests are sent to both 8-bit and 16-bit areas, which separates split from unsplit sequencing and checks that the wait sequence is repeated per half. The same area fields are decoded with the DRAM-span bit set and clear. A held external wait and a brief one that falls inside the long-wait window are applied in turn, which shows the wait line is read only after the long waits and only through the synchronizer.

// File: rtl/ebac_pkg.sv
package ebac_pkg;

    parameter int NUM_AREAS   = 8;
    parameter int AREA_W      = $clog2(NUM_AREAS);
    parameter int AREA_LSB    = 22;
    parameter int ADDR_W      = AREA_LSB + AREA_W;
    parameter int WAIT_W      = 2;
    parameter int SYNC_STAGES = 2;
    parameter int DRAM_SPAN   = 4;
    parameter logic [NUM_AREAS-1:0] LW_MASK = 8'b0100_0101;

    typedef logic [AREA_W-1:0] area_t;
    typedef logic [WAIT_W:0]   wcnt_t;

    localparam area_t DRAM_AREA = area_t'(1);
    localparam area_t DRAM_LAST = area_t'(1 + DRAM_SPAN - 1);

    typedef struct packed {
        logic              wide;
        logic [WAIT_W-1:0] lwait;
    } area_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } seq_state_e;

    function automatic logic has_long_wait(area_t a);
        return LW_MASK[a];
    endfunction

    function automatic wcnt_t wait_reload(area_t a, area_cfg_t c);
        if (has_long_wait(a))
            return wcnt_t'(c.lwait) + wcnt_t'(1);
        return '0;
    endfunction

endpackage

// File: rtl/ebac_cfg_regs.sv
module ebac_cfg_regs
    import ebac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  area_t             wr_area,
    input  logic              wr_wide,
    input  logic [WAIT_W-1:0] wr_lwait,
    input  logic              wr_dram,
    output area_cfg_t         cfg_o [NUM_AREAS],
    output logic              dram_o
);

    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
        logic hit;
        assign hit = we && (wr_area == area_t'(i));

        always_ff @(posedge clk) begin
            if (rst)      cfg_o[i].wide <= 1'b0;
            else if (hit) cfg_o[i].wide <= wr_wide;
        end

        if (LW_MASK[i]) begin : g_lw
            always_ff @(posedge clk) begin
                if (rst)      cfg_o[i].lwait <= '0;
                else if (hit) cfg_o[i].lwait <= wr_lwait;
            end
        end else begin : g_nolw
            assign cfg_o[i].lwait = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                dram_o <= 1'b0;
        else if (we && wr_area == DRAM_AREA)    dram_o <= wr_dram;
    end

endmodule

// File: rtl/ebac_area_decode.sv
module ebac_area_decode
    import ebac_pkg::*;
(
    input  area_t field,
    input  logic  dram_span,
    output area_t area
);

    always_comb begin
        area = field;
        if (dram_span && field >= DRAM_AREA && field <= DRAM_LAST)
            area = DRAM_AREA;
    end

endmodule

// File: rtl/ebac_seq.sv
module ebac_seq
    import ebac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_word,
    input  area_t                req_area,
    input  area_cfg_t            req_cfg,
    input  logic                 wait_s,
    output logic [NUM_AREAS-1:0] cs,
    output logic                 bus_wide,
    output logic                 bus_we,
    output logic                 half_hi,
    output logic                 ready
);

    seq_state_e state;
    area_t      area_q;
    logic       wide_q, we_q, split_q, first_q;
    wcnt_t      reload_q, wcnt;
    logic       cycle_end;

    assign cycle_end = (state == ST_BUS) && (wcnt == '0) && !wait_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            area_q   <= '0;
            wide_q   <= 1'b0;
            we_q     <= 1'b0;
            split_q  <= 1'b0;
            first_q  <= 1'b0;
            reload_q <= '0;
            wcnt     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state    <= ST_BUS;
                        area_q   <= req_area;
                        wide_q   <= req_cfg.wide;
                        we_q     <= req_write;
                        split_q  <= req_word && !req_cfg.wide;
                        first_q  <= 1'b1;
                        reload_q <= wait_reload(req_area, req_cfg);
                        wcnt     <= wait_reload(req_area, req_cfg);
                    end
                end
                ST_BUS: begin
                    if (wcnt != '0) begin
                        wcnt <= wcnt - wcnt_t'(1);
                    end else if (cycle_end) begin
                        if (split_q && first_q) begin
                            first_q <= 1'b0;
                            wcnt    <= reload_q;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_AREAS; i++)
            cs[i] = (state == ST_BUS) && (area_q == area_t'(i));
    end

    assign bus_wide = (state == ST_BUS) && wide_q;
    assign bus_we   = (state == ST_BUS) && we_q;
    assign half_hi  = (state == ST_BUS) && split_q && first_q;
    assign ready    = cycle_end && !(split_q && first_q);

endmodule

// File: rtl/ext_bus_area_ctrl.sv
module ext_bus_area_ctrl
    import ebac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 req_word,
    input  logic                 cfg_we,
    input  logic [AREA_W-1:0]    cfg_area,
    input  logic                 cfg_wide,
    input  logic [WAIT_W-1:0]    cfg_lwait,
    input  logic                 cfg_dram,
    input  logic                 ext_wait,
    output logic [NUM_AREAS-1:0] cs,
    output logic                 bus_wide,
    output logic                 bus_we,
    output logic                 half_hi,
    output logic                 ready
);

    area_cfg_t              cfg_all [NUM_AREAS];
    logic                   dram_span;
    area_t                  area_sel;
    logic [SYNC_STAGES-1:0] wsync;
    logic                   unused_offset;

    assign unused_offset = ^req_addr[AREA_LSB-1:0];

    always_ff @(posedge clk) begin
        if (rst) wsync <= '0;
        else     wsync <= {wsync[SYNC_STAGES-2:0], ext_wait};
    end

    ebac_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wr_area  (cfg_area),
        .wr_wide  (cfg_wide),
        .wr_lwait (cfg_lwait),
        .wr_dram  (cfg_dram),
        .cfg_o    (cfg_all),
        .dram_o   (dram_span)
    );

    ebac_area_decode u_dec (
        .field     (req_addr[ADDR_W-1:AREA_LSB]),
        .dram_span (dram_span),
        .area      (area_sel)
    );

    ebac_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_area  (area_sel),
        .req_cfg   (cfg_all[area_sel]),
        .wait_s    (wsync[SYNC_STAGES-1]),
        .cs        (cs),
        .bus_wide  (bus_wide),
        .bus_we    (bus_we),
        .half_hi   (half_hi),
        .ready     (ready)
    );

endmodule

// File: rtl/ebac_checker.sv
module ebac_checker
    import ebac_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_AREAS-1:0] cs,
    input logic                 bus_wide,
    input logic                 bus_we,
    input logic                 half_hi,
    input logic                 ready
);

    AST_CS_ONEHOT:      assert property (@(posedge clk) disable iff (rst) $onehot0(cs));                              // R1
    AST_CS_HOLD:        assert property (@(posedge clk) disable iff (rst) (cs != '0 && !ready) |=> cs == $past(cs));   // R1
    AST_WIDE_HOLD:      assert property (@(posedge clk) disable iff (rst) (cs != '0 && !ready) |=> $stable(bus_wide)); // R3
    AST_WE_NEEDS_CS:    assert property (@(posedge clk) disable iff (rst) bus_we |-> cs != '0);                        // R3
    AST_SPLIT_NARROW:   assert property (@(posedge clk) disable iff (rst) half_hi |-> !bus_wide && !ready);            // R6
    AST_READY_WITH_CS:  assert property (@(posedge clk) disable iff (rst) ready |-> $countones(cs) == 1);              // R9
    AST_READY_PULSE:    assert property (@(posedge clk) disable iff (rst) ready |=> !ready && cs == '0);               // R9

endmodule

bind ext_bus_area_ctrl ebac_checker u_ebac_checker (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .bus_wide (bus_wide),
    .bus_we   (bus_we),
    .half_hi  (half_hi),
    .ready    (ready)
);

// File: tb/ext_bus_area_ctrl_bench.sv
module ext_bus_area_ctrl_bench;
    import ebac_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic                 req_write = 1'b0;
    logic                 req_word = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [AREA_W-1:0]    cfg_area = '0;
    logic                 cfg_wide = 1'b0;
    logic [WAIT_W-1:0]    cfg_lwait = '0;
    logic                 cfg_dram = 1'b0;
    logic                 ext_wait = 1'b0;
    logic [NUM_AREAS-1:0] cs;
    logic                 bus_wide, bus_we, half_hi, ready;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ext_bus_area_ctrl u_ext_bus_area_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_word(req_word), .cfg_we(cfg_we),
        .cfg_area(cfg_area), .cfg_wide(cfg_wide), .cfg_lwait(cfg_lwait),
        .cfg_dram(cfg_dram), .ext_wait(ext_wait), .cs(cs), .bus_wide(bus_wide),
        .bus_we(bus_we), .half_hi(half_hi), .ready(ready)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] addr_of(input int field);
        return (ADDR_W'(field) << AREA_LSB) | ADDR_W'(22'h01_2346);
    endfunction

    task automatic cfg_write(input int area, input logic wide, input int lw, input logic dram);
        @(negedge clk);
        cfg_we = 1'b1; cfg_area = AREA_W'(area); cfg_wide = wide;
        cfg_lwait = WAIT_W'(lw); cfg_dram = dram;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access from an idle negedge; measures cycles to ready and checks
    // chip-select, width, write flag, split marker and the idle gap after it.
    task automatic do_access(input string req, input int field, input logic word,
                             input logic wr, input int exp_area, input int exp_len,
                             input logic exp_wide, input logic exp_split, input logic pulse);
        int  n = 0;
        bit  got = 0;
        bit  cs_ok = 1;
        req_valid = 1'b1; req_addr = addr_of(field); req_word = word; req_write = wr;
        @(posedge clk);
        while (!got && n < 40) begin
            @(negedge clk);
            n++;
            if (pulse) ext_wait = (n == 1);
            if (cs != NUM_AREAS'(1) << exp_area) cs_ok = 0;
            if (n == 1) check(req, "half_hi in first cycle", int'(half_hi), int'(exp_split));
            got = ready;
        end
        check(req, "chip-select held on area", int'(cs_ok), 1);
        check(req, "cycles to ready", n, exp_len);
        check("R3", "bus_wide at ready", int'(bus_wide), int'(exp_wide));
        check("R3", "bus_we at ready", int'(bus_we), int'(wr));
        @(negedge clk);
        check("R9", "chip-selects low after ready with request held", int'(cs), 0);
        check("R9", "ready pulse ends", int'(ready), 0);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R10", "cs after reset", int'(cs), 0);
        check("R10", "ready after reset", int'(ready), 0);
        check("R10", "half_hi after reset", int'(half_hi), 0);
        check("R10", "bus_wide/bus_we after reset", int'({bus_wide, bus_we}), 0);
    endtask

    task automatic t_decode_and_defaults;
        do_access("R1", 3, 1'b0, 1'b0, 3, 1, 1'b0, 1'b0, 1'b0);
        do_access("R1", 7, 1'b0, 1'b1, 7, 1, 1'b0, 1'b0, 1'b0);
        do_access("R4", 6, 1'b0, 1'b0, 6, 2, 1'b0, 1'b0, 1'b0); // reset long wait = 1
    endtask

    task automatic t_long_wait;
        cfg_write(2, 1'b0, 2, 1'b0);
        do_access("R4", 2, 1'b0, 1'b0, 2, 4, 1'b0, 1'b0, 1'b0);
        cfg_write(0, 1'b0, 3, 1'b0);
        do_access("R4", 0, 1'b0, 1'b1, 0, 5, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_no_long_wait;
        cfg_write(3, 1'b0, 3, 1'b0);
        do_access("R5", 3, 1'b0, 1'b0, 3, 1, 1'b0, 1'b0, 1'b0);
        cfg_write(7, 1'b0, 3, 1'b0);
        do_access("R5", 7, 1'b0, 1'b0, 7, 1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_width;
        cfg_write(4, 1'b1, 0, 1'b0);
        do_access("R6", 4, 1'b1, 1'b1, 4, 1, 1'b1, 1'b0, 1'b0);
        do_access("R6", 5, 1'b1, 1'b0, 5, 2, 1'b0, 1'b1, 1'b0);
        do_access("R6", 5, 1'b0, 1'b0, 5, 1, 1'b0, 1'b0, 1'b0);
        do_access("R6", 0, 1'b1, 1'b0, 0, 10, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_dram_span;
        cfg_write(1, 1'b0, 0, 1'b1);
        do_access("R2", 3, 1'b0, 1'b0, 1, 1, 1'b0, 1'b0, 1'b0);
        do_access("R2", 4, 1'b0, 1'b0, 1, 1, 1'b0, 1'b0, 1'b0);
        do_access("R2", 5, 1'b0, 1'b0, 5, 1, 1'b0, 1'b0, 1'b0);
        cfg_write(1, 1'b0, 0, 1'b0);
        do_access("R2", 3, 1'b0, 1'b0, 3, 1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ext_wait;
        int  n = 0;
        bit  held = 1;
        ext_wait = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_addr = addr_of(3); req_word = 1'b0; req_write = 1'b0;
        @(posedge clk);
        repeat (4) begin
            @(negedge clk);
            if (cs != 8'h08 || ready) held = 0;
        end
        check("R7", "access held while wait high", int'(held), 1);
        ext_wait = 1'b0;
        while (!ready && n < 20) begin
            @(negedge clk);
            n++;
        end
        check("R7", "cycles from wait release to ready", n, 2);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_wait_pulse;
        // area 0 has long-wait field 3 (4 waits); pulse lands inside the window
        do_access("R8", 0, 1'b0, 1'b0, 0, 5, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode_and_defaults();
        t_long_wait();
        t_no_long_wait();
        t_width();
        t_dram_span();
        t_ext_wait();
        t_wait_pulse();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule